// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block decides which result slot an analog-to-digital converter works on next and when each conversion begins. It keeps sixteen slot control entries. Each entry holds a channel code and an end-of-sequence marker. The block also holds a start slot and a two-bit mode. From these it issues a one-cycle sample request to the converter core, presents the current slot index and its channel code, and produces a one-cycle result write strobe when the core finishes. The core is modelled inside the block as a fixed latency of `CONV_LAT` cycles, counted from the sample request.

Software loads the start slot and the entries while the enable input is low. Raising enable arms the block, and a rising edge on the trigger input starts the first conversion. The block can convert once or repeatedly, and it can convert one slot or a run of slots. In the repeating modes the mode field stays writable, so the operating mode can change without stopping. The new mode is adopted at the next sequence boundary.

Top module: `conv_sequencer`

## Requirements
- R1: Mode encoding is 0 = one slot converted once, 1 = a slot run converted once, 2 = one slot converted repeatedly, 3 = a slot run converted repeatedly. The mode is captured when enable rises.
- R2: `chanCode` always equals bits 3:0 of the control entry of the slot shown on `slotIdx`. Bit 7 of an entry is its end-of-sequence marker.
- R3: Every run starts at the start slot. In modes 1 and 3 the slot advances by one after each conversion, and the run ends after the first slot whose bit 7 is set. Slot 15 advances to slot 0.
- R4: In modes 0 and 1, once the run completes, further trigger edges are ignored until enable falls and rises again.
- R5: In modes 2 and 3 conversions continue until enable is cleared. With enable low at the done cycle, operation stops after that conversion.
- R6: In a repeating mode, a newly written mode value other than 0 takes effect only when the current run ends. A written value of 0 stops operation after the conversion in progress.
- R7: With `multiSample` high in modes 1 to 3, only the first conversion needs a trigger rising edge, and each later conversion starts in the done cycle of the previous one. With `multiSample` low, every conversion waits for a new trigger rising edge.
- R8: `resWr` is a one-cycle pulse in the `CONV_LAT`-th cycle of a conversion, where the sample-request cycle is the first. During it, `slotIdx` is the slot written and `resData` equals `convData`. `resData` is 0 otherwise.
- R9: `busy` is high exactly during the `CONV_LAT` cycles of a conversion in mode 0 and stays low in every other mode.
- R10: Writes to the start slot and to control entries are ignored while enable is 1. Mode writes are accepted at any time.
- R11: `sampleReq` is a one-cycle pulse. It is issued in the cycle after an accepted trigger rising edge, or in the cycle after a chained done, and only if enable was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for mode and start slot |
| cfgMode | input | 2 | Mode value to write |
| cfgStart | input | 4 | Start slot to write (taken only while enable is low) |
| entWrEn | input | 1 | Control entry write strobe (taken only while enable is low) |
| entAddr | input | 4 | Control entry index |
| entData | input | 8 | Entry: bit 7 end-of-sequence, bits 6:4 spare, bits 3:0 channel |
| enable | input | 1 | Conversion enable |
| multiSample | input | 1 | Chain conversions after the first trigger |
| trigger | input | 1 | Sample trigger; rising edge starts a conversion |
| convData | input | 12 | Result word offered by the converter core |
| slotIdx | output | 4 | Current slot |
| chanCode | output | 4 | Channel code of the current slot |
| sampleReq | output | 1 | One-cycle sample request to the core |
| resWr | output | 1 | One-cycle result write strobe |
| resData | output | 12 | Result written with `resWr` |
| busy | output | 1 | Conversion in progress in mode 0 |

## Verification
The sharpest collision is a done cycle that also has to start the next conversion. In that same cycle the result write, the slot advance or reload, the mode adoption and the chained request all fall due. With `multiSample` high in modes 1 to 3, the bench places these edges back to back. In mode 3 it rewrites the mode while the block runs. A behavioural reference model is compared every cycle against the slot, channel, request, strobe, data and busy outputs. Scenario tallies of write counts and of the last slot written then judge the re-arm, stop and deferral rules.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2,
    ST_HOLD  = 2'd3
  } seqState_e;

  // strobes issued by the control FSM towards the datapath
  typedef struct packed {
    logic loadSeq;    // slot <- start, active mode <- mode register
    logic advance;    // slot <- slot + 1 (wrapping)
    logic startConv;  // issue a sample request and restart the latency count
  } seqStrobe_t;
endpackage

// File: rtl/conv_seq_dp.sv
module conv_seq_dp
  import conv_seq_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int ENT_W    = 8,
  parameter int EOS_BIT  = 7,
  parameter int CH_W     = 4,
  parameter int RES_W    = 12,
  parameter int MODE_W   = 2,
  parameter int CONV_LAT = 4,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(CONV_LAT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [SLOT_W-1:0] cfgStart,
  input  logic              entWrEn,
  input  logic [SLOT_W-1:0] entAddr,
  input  logic [ENT_W-1:0]  entData,
  input  logic              enable,
  input  seqStrobe_t        strb,
  input  logic [RES_W-1:0]  convData,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [CH_W-1:0]   chanCode,
  output logic              eosCur,
  output logic [MODE_W-1:0] activeMode,
  output logic [MODE_W-1:0] modeReg,
  output logic              convDone,
  output logic              sampleReq,
  output logic              resWr,
  output logic [RES_W-1:0]  resData
);
  logic [ENT_W-1:0]  entQ [SLOTS];
  logic [SLOT_W-1:0] startQ;
  logic [SLOT_W-1:0] slotQ;
  logic [MODE_W-1:0] modeQ;
  logic [MODE_W-1:0] actQ;
  logic [CNT_W-1:0]  cntQ;
  logic              runQ;
  logic              reqQ;
  logic [SLOT_W-1:0] slotNext;

  // configuration registers: start and entries locked while enabled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      startQ <= '0;
      for (int i = 0; i < SLOTS; i++) entQ[i] <= '0;
    end else begin
      if (cfgWrEn) modeQ <= cfgMode;
      if (cfgWrEn && !enable) startQ <= cfgStart;
      if (entWrEn && !enable) entQ[entAddr] <= entData;
    end
  end

  // wrapping slot increment; power-of-two depth wraps naturally
  generate
    if ((1 << SLOT_W) == SLOTS) begin : gWrapPow2
      assign slotNext = slotQ + 1'b1;
    end else begin : gWrapCmp
      assign slotNext = (slotQ == SLOT_W'(SLOTS - 1)) ? '0 : slotQ + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
      actQ  <= '0;
    end else if (strb.loadSeq) begin
      slotQ <= startQ;
      actQ  <= modeQ;
    end else if (strb.advance) begin
      slotQ <= slotNext;
    end
  end

  // fixed-latency converter model
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      runQ <= 1'b0;
      reqQ <= 1'b0;
    end else begin
      reqQ <= strb.startConv;
      if (strb.startConv) begin
        cntQ <= '0;
        runQ <= 1'b1;
      end else if (convDone) begin
        runQ <= 1'b0;
      end else if (runQ) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign convDone   = runQ && (cntQ == CNT_W'(CONV_LAT - 1));
  assign slotIdx    = slotQ;
  assign chanCode   = entQ[slotQ][CH_W-1:0];
  assign eosCur     = entQ[slotQ][EOS_BIT];
  assign activeMode = actQ;
  assign modeReg    = modeQ;
  assign sampleReq  = reqQ;
  assign resWr      = convDone;
  assign resData    = convDone ? convData : '0;
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              trigger,
  input  logic              multiSample,
  input  logic              convDone,
  input  logic              eosCur,
  input  logic [MODE_W-1:0] activeMode,
  input  logic [MODE_W-1:0] modeReg,
  output seqStrobe_t        strb,
  output logic              busy
);
  seqState_e stateQ, stateD;
  logic      trigPrev;
  logic      trigRise;
  logic      seqMode;
  logic      repMode;
  logic      lastInRun;

  assign trigRise  = trigger && !trigPrev;
  assign seqMode   = activeMode[0];
  assign repMode   = activeMode[1];
  assign lastInRun = !seqMode || eosCur;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (enable) begin
          strb.loadSeq = 1'b1;
          stateD       = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (!enable) begin
          stateD = ST_IDLE;
        end else if (trigRise) begin
          strb.startConv = 1'b1;
          stateD         = ST_CONV;
        end
      end
      ST_CONV: begin
        if (convDone) begin
          if (!enable) begin
            stateD = ST_IDLE;
          end else if (!repMode) begin
            if (lastInRun) begin
              stateD = ST_HOLD;
            end else begin
              strb.advance = 1'b1;
              if (multiSample) strb.startConv = 1'b1;
              else             stateD = ST_ARMED;
            end
          end else if (modeReg == '0) begin
            stateD = ST_HOLD;
          end else begin
            if (lastInRun) strb.loadSeq = 1'b1;
            else           strb.advance = 1'b1;
            if (multiSample) strb.startConv = 1'b1;
            else             stateD = ST_ARMED;
          end
        end
      end
      ST_HOLD: begin
        if (!enable) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      trigPrev <= 1'b0;
    end else begin
      stateQ   <= stateD;
      trigPrev <= trigger;
    end
  end

  assign busy = (stateQ == ST_CONV) && (activeMode == '0);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int ENT_W    = 8,
  parameter int EOS_BIT  = 7,
  parameter int CH_W     = 4,
  parameter int RES_W    = 12,
  parameter int MODE_W   = 2,
  parameter int CONV_LAT = 4,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [SLOT_W-1:0] cfgStart,
  input  logic              entWrEn,
  input  logic [SLOT_W-1:0] entAddr,
  input  logic [ENT_W-1:0]  entData,
  input  logic              enable,
  input  logic              multiSample,
  input  logic              trigger,
  input  logic [RES_W-1:0]  convData,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [CH_W-1:0]   chanCode,
  output logic              sampleReq,
  output logic              resWr,
  output logic [RES_W-1:0]  resData,
  output logic              busy
);
  seqStrobe_t        strb;
  logic              convDone;
  logic              eosCur;
  logic [MODE_W-1:0] activeMode;
  logic [MODE_W-1:0] modeReg;

  conv_seq_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .trigger    (trigger),
    .multiSample(multiSample),
    .convDone   (convDone),
    .eosCur     (eosCur),
    .activeMode (activeMode),
    .modeReg    (modeReg),
    .strb       (strb),
    .busy       (busy)
  );

  conv_seq_dp #(
    .SLOTS(SLOTS), .ENT_W(ENT_W), .EOS_BIT(EOS_BIT), .CH_W(CH_W),
    .RES_W(RES_W), .MODE_W(MODE_W), .CONV_LAT(CONV_LAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgMode   (cfgMode),
    .cfgStart  (cfgStart),
    .entWrEn   (entWrEn),
    .entAddr   (entAddr),
    .entData   (entData),
    .enable    (enable),
    .strb      (strb),
    .convData  (convData),
    .slotIdx   (slotIdx),
    .chanCode  (chanCode),
    .eosCur    (eosCur),
    .activeMode(activeMode),
    .modeReg   (modeReg),
    .convDone  (convDone),
    .sampleReq (sampleReq),
    .resWr     (resWr),
    .resData   (resData)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              sampleReq,
  input logic              resWr,
  input logic              busy,
  input logic [SLOT_W-1:0] slotIdx
);
  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq);

  // R11
  req_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> $past(enable));

  // R8
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resWr |=> !resWr);

  // R8
  wr_not_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    resWr |-> !sampleReq);

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> $stable(slotIdx));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sampleReq);
endmodule

bind conv_sequencer conv_seq_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .sampleReq(sampleReq),
  .resWr    (resWr),
  .busy     (busy),
  .slotIdx  (slotIdx)
);

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [3:0]  cfgStart = 4'd0;
  logic        entWrEn = 1'b0;
  logic [3:0]  entAddr = 4'd0;
  logic [7:0]  entData = 8'd0;
  logic        enable = 1'b0;
  logic        multiSample = 1'b0;
  logic        trigger = 1'b0;
  logic [11:0] convData = 12'h0;
  logic [3:0]  slotIdx;
  logic [3:0]  chanCode;
  logic        sampleReq;
  logic        resWr;
  logic [11:0] resData;
  logic        busy;

  conv_sequencer #(.CONV_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgStart(cfgStart), .entWrEn(entWrEn), .entAddr(entAddr),
    .entData(entData), .enable(enable), .multiSample(multiSample),
    .trigger(trigger), .convData(convData), .slotIdx(slotIdx),
    .chanCode(chanCode), .sampleReq(sampleReq), .resWr(resWr),
    .resData(resData), .busy(busy)
  );

  always #4 clk = ~clk;

  integer vecs = 0;
  integer fails = 0;
  bit     finished = 1'b0;

  task automatic chk(input string tag, input integer act, input integer exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  integer   ph, left, mSlot, act, mMode, mStart;
  bit [7:0] ent [16];
  bit       pTrig, sreq;

  always @(posedge clk) begin
    #1 convData = convData + 12'h13b;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; left = 0; mSlot = 0; act = 0; mMode = 0; mStart = 0;
      pTrig = 0; sreq = 0;
      for (int i = 0; i < 16; i++) ent[i] = 8'h00;
    end else begin
      bit rise, nreq, last;
      rise = trigger && !pTrig;
      nreq = 0;
      case (ph)
        0: if (enable) begin ph = 1; mSlot = mStart; act = mMode; end
        1: if (!enable) ph = 0;
           else if (rise) begin ph = 2; left = LAT; nreq = 1; end
        2: if (left > 1) left = left - 1;
           else begin
             last = (act % 2 == 0) || ent[mSlot][7];
             if (!enable) ph = 0;
             else if (act < 2) begin
               if (last) ph = 3;
               else begin
                 mSlot = (mSlot + 1) % 16;
                 if (multiSample) begin left = LAT; nreq = 1; end else ph = 1;
               end
             end else if (mMode == 0) ph = 3;
             else begin
               if (last) begin mSlot = mStart; act = mMode; end
               else mSlot = (mSlot + 1) % 16;
               if (multiSample) begin left = LAT; nreq = 1; end else ph = 1;
             end
           end
        default: if (!enable) ph = 0;
      endcase
      sreq = nreq;
      if (cfgWrEn) mMode = cfgMode;
      if (cfgWrEn && !enable) mStart = cfgStart;
      if (entWrEn && !enable) ent[entAddr] = entData;
      pTrig = trigger;
    end
  end

  integer wrCnt = 0;
  integer busyCnt = 0;
  integer lastSlot = 0;
  integer wrSlots [$];

  always @(negedge clk) begin
    if (rstN) begin
      bit eWr;
      eWr = (ph == 2) && (left == 1);
      chk("R3 slotIdx", slotIdx, mSlot);
      chk("R2 chanCode", chanCode, ent[mSlot][3:0]);
      chk("R11 sampleReq", sampleReq, sreq);
      chk("R8 resWr", resWr, eWr);
      chk("R8 resData", resData, eWr ? convData : 0);
      chk("R9 busy", busy, (act == 0) && (ph == 2));
      if (resWr) begin wrCnt++; lastSlot = slotIdx; wrSlots.push_back(slotIdx); end
      if (busy) busyCnt++;
    end
  end

  task automatic tick(input integer n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setEnt(input integer a, input integer d);
    entWrEn = 1; entAddr = 4'(a); entData = 8'(d);
    tick(1);
    entWrEn = 0;
  endtask

  task automatic setCfg(input integer m, input integer s);
    cfgWrEn = 1; cfgMode = 2'(m); cfgStart = 4'(s);
    tick(1);
    cfgWrEn = 0;
  endtask

  task automatic pulse();
    trigger = 1; tick(1); trigger = 0; tick(1);
  endtask

  task automatic rearm();
    enable = 0; tick(2); enable = 1; tick(2);
  endtask

  initial begin
    integer w0;
    tick(3);
    rstN = 1;
    #2;
    // reset state
    chk("R8 reset resWr", resWr, 0);
    chk("R11 reset sampleReq", sampleReq, 0);
    chk("R9 reset busy", busy, 0);
    chk("R3 reset slot", slotIdx, 0);
    tick(1);

    setEnt(3, 8'h05); setEnt(4, 8'h06); setEnt(5, 8'h87);
    setEnt(15, 8'h09); setEnt(0, 8'h81);
    setCfg(0, 3);

    // mode 0: one conversion, then re-arm needed
    enable = 1; tick(2);
    w0 = wrCnt; busyCnt = 0;
    pulse(); tick(10);
    chk("R1 mode0 writes", wrCnt - w0, 1);
    chk("R9 mode0 busy cycles", busyCnt, LAT);
    chk("R1 mode0 slot", lastSlot, 3);
    pulse(); tick(10);
    chk("R4 trigger ignored before re-arm", wrCnt - w0, 1);
    rearm(); pulse(); tick(10);
    chk("R4 converts after re-arm", wrCnt - w0, 2);

    // write lock while enabled
    setEnt(3, 8'h0c); setCfg(0, 7);
    rearm(); tick(1);
    chk("R10 start slot locked", slotIdx, 3);
    chk("R10 entry locked", chanCode, 5);

    // mode 1, per-trigger
    enable = 0; setCfg(1, 3); enable = 1; tick(2);
    w0 = wrCnt; busyCnt = 0;
    pulse(); tick(8);
    chk("R7 one write per trigger", wrCnt - w0, 1);
    pulse(); tick(8); pulse(); tick(8);
    chk("R3 run ends at marked slot", wrCnt - w0, 3);
    chk("R3 last slot", lastSlot, 5);
    pulse(); tick(8);
    chk("R4 run done ignores trigger", wrCnt - w0, 3);
    chk("R9 no busy outside mode0", busyCnt, 0);

    // mode 1, chained
    multiSample = 1; rearm();
    w0 = wrCnt; pulse(); tick(30);
    chk("R7 chained run writes", wrCnt - w0, 3);

    // wrap from 15 to 0
    enable = 0; setCfg(1, 15); enable = 1; tick(2);
    w0 = wrCnt; wrSlots.delete();
    pulse(); tick(20);
    chk("R3 wrap writes", wrCnt - w0, 2);
    if (wrSlots.size() == 2) begin
      chk("R3 wrap first slot", wrSlots[0], 15);
      chk("R3 wrap second slot", wrSlots[1], 0);
    end

    // mode 2 repeat until enable drops
    enable = 0; setCfg(2, 3); enable = 1; tick(2);
    w0 = wrCnt; busyCnt = 0;
    pulse(); tick(40);
    chk("R5 repeat keeps going", (wrCnt - w0) >= 5, 1);
    enable = 0; tick(10);
    w0 = wrCnt; tick(20);
    chk("R5 stopped after enable low", wrCnt - w0, 0);
    chk("R9 no busy in repeat", busyCnt, 0);

    // mode 3 then switch to mode 1 (deferred)
    setCfg(3, 3); enable = 1; tick(2);
    w0 = wrCnt; pulse(); tick(17);
    setCfg(1, 3); tick(60);
    chk("R6 whole runs only", (wrCnt - w0) % 3, 0);
    chk("R6 ends at marked slot", lastSlot, 5);
    w0 = wrCnt; tick(20);
    chk("R6 single-shot adopted", wrCnt - w0, 0);

    // mode 3 then switch to mode 0 (stop after current)
    enable = 0; setCfg(3, 3); enable = 1; tick(2);
    w0 = wrCnt; pulse(); tick(15);
    setCfg(0, 3); tick(10);
    w0 = wrCnt; tick(20);
    chk("R6 mode0 write stops", wrCnt - w0, 0);

    // mode 3 with per-trigger, multiSample off
    multiSample = 0; enable = 0; setCfg(3, 4); enable = 1; tick(2);
    w0 = wrCnt;
    pulse(); tick(8); pulse(); tick(8); pulse(); tick(8);
    chk("R7 repeat per-trigger writes", wrCnt - w0, 3);
    chk("R3 reload to start", lastSlot, 4);
    enable = 0; tick(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      vecs++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule